// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Ownership Hold

This block decides which of several masters owns a shared bus. Every master has a private request line, a private grant line and a private finish line. A master raises its request and waits. Once its grant is high it owns the bus, and it keeps the bus for as many cycles as its transfer needs. It gives the bus up by pulsing its finish line for one cycle. Grants therefore follow transactions, not single clock cycles.

A rotating search pointer picks the winner. The search starts at the slot just after the last master that won, so a master that sits low in the order still reaches the bus within one full rotation. A lookahead network keeps evaluating the pending requests while a transaction runs. Because of this, the master chosen at the owner's finish holds the grant on the very next cycle and no idle cycle falls between owners. The owner never competes in the decision made at its own release. If it still wants the bus, it gets it only through a later decision.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset every grant is low and the search pointer is at master 0. With all four masters requesting, master 0 is therefore granted first.
- R2: At most one grant line is high in any cycle.
- R3: The owner keeps its grant until it pulses its own finish line. The owner dropping its request does not end ownership, and neither does any other input.
- R4: With no owner, a request seen at a clock edge produces a grant visible after that same edge, one register stage later.
- R5: The search order starts at the slot just after the last granted master and wraps from the highest index to index 0.
- R6: When the owner finishes at a clock edge and another master is requesting, the new owner's grant is high right after that edge, so no cycle passes without an owner.
- R7: When the owner finishes and no other master is requesting, all grants are low after that edge. The finishing owner is not considered in that decision, even if its own request is still high.
- R8: A master that withdraws its request before it is granted is ignored from the cycle of withdrawal onward.
- R9: A finish pulse from a master that does not own the bus has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_MASTERS | Request line, one bit per master |
| fin | input | N_MASTERS | Finish pulse, one bit per master; only the owner's bit counts |
| gnt | output | N_MASTERS | Grant line, one bit per master, at most one high |

## Verification
The hardest case to reach is a handover where the lookahead choice changes in the last cycle before the release. A master that was waiting withdraws its request in the same cycle that the owner pulses finish, and the pointer must then skip to the next requester. The vector walk first builds a known pointer position through a chain of ownerships. It then issues that withdrawal together with the finish, and separately releases an owner whose own request is still high. A mid-transaction reset then shows that the grant clears at once and that the rotation restarts at master 0.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Modular addition of slot indices for the rotating search.
  function automatic int unsigned slot_add(int unsigned a, int unsigned b,
                                           int unsigned n);
    int unsigned s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick import arb_pkg::*; #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] ptr,
  output logic          win_vld,
  output logic [IW-1:0] win_idx,
  output logic [N-1:0]  win_oh
);
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      int unsigned k;
      k = slot_add(int'(ptr), i, N);
      if (!win_vld && cand[k]) begin
        win_vld = 1'b1;
        win_idx = IW'(k);
      end
    end
  end

  always_comb begin
    win_oh = '0;
    if (win_vld) win_oh[win_idx] = 1'b1;
  end

  // R5: a chosen winner is always a live candidate.
  a_r5_winner_requested: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> ((cand & win_oh) != '0));
  // R8: no candidate means no winner.
  a_r8_empty_no_win: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> !win_vld);
endmodule

// File: rtl/grant_ctl.sv
module grant_ctl #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  fin,
  input  logic          win_vld,
  input  logic [IW-1:0] win_idx,
  input  logic [N-1:0]  win_oh,
  output logic [N-1:0]  cand,
  output logic [IW-1:0] ptr,
  output logic [N-1:0]  gnt
);
  logic          busy, take;
  logic [N-1:0]  gnt_nx;
  logic [IW-1:0] ptr_nx;
  logic          ptr_en;

  assign busy = |gnt;
  // The owner is left out of the lookahead decision.
  assign cand = busy ? (req & ~gnt) : req;
  assign take = busy ? |(fin & gnt) : 1'b1;

  always_comb begin
    gnt_nx = gnt;
    ptr_nx = ptr;
    ptr_en = 1'b0;
    if (take) begin
      gnt_nx = win_vld ? win_oh : '0;
      if (win_vld) begin
        ptr_en = 1'b1;
        ptr_nx = (win_idx == IW'(N-1)) ? '0 : win_idx + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt <= '0;
      ptr <= '0;
    end else begin
      if (take)   gnt <= gnt_nx;
      if (ptr_en) ptr <= ptr_nx;
    end
  end

  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r3_hold_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ((fin & gnt) == '0)) |=> (gnt == $past(gnt)));
  a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ((fin & gnt) != '0) && ((req & ~gnt) != '0)) |=> (gnt != '0));
  a_r7_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ((fin & gnt) != '0) && ((req & ~gnt) == '0)) |=> (gnt == '0));
  a_r4_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (req == '0)) |=> (gnt == '0));
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic [N_MASTERS-1:0] fin,
  output logic [N_MASTERS-1:0] gnt
);
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

  logic [N_MASTERS-1:0] cand, win_oh;
  logic [IW-1:0]        ptr, win_idx;
  logic                 win_vld;

  rr_pick #(.N(N_MASTERS)) u_pick (
    .clk(clk), .rst_n(rst_n), .cand(cand), .ptr(ptr),
    .win_vld(win_vld), .win_idx(win_idx), .win_oh(win_oh)
  );

  grant_ctl #(.N(N_MASTERS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .req(req), .fin(fin),
    .win_vld(win_vld), .win_idx(win_idx), .win_oh(win_oh),
    .cand(cand), .ptr(ptr), .gnt(gnt)
  );
endmodule

// File: tb/bus_hold_arbiter_test.sv
module bus_hold_arbiter_test;
  localparam int PERIOD = 10;
  localparam int NV = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] fin = '0;
  logic [3:0] gnt;
  int checks = 0;
  int fails  = 0;

  bus_hold_arbiter #(.N_MASTERS(4)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .fin(fin), .gnt(gnt)
  );

  always #(PERIOD/2) clk = ~clk;

  // {req, fin, expected gnt after the edge}
  localparam logic [11:0] VEC [NV] = '{
    {4'b0000, 4'b0000, 4'b0000}, // R1 idle after reset
    {4'b1111, 4'b0000, 4'b0001}, // R1 R4 pointer at 0
    {4'b1111, 4'b0010, 4'b0001}, // R9 non-owner finish ignored
    {4'b1110, 4'b0000, 4'b0001}, // R3 owner drops request, still owns
    {4'b1110, 4'b0001, 4'b0010}, // R6 R5 handover to slot 1
    {4'b1101, 4'b0010, 4'b0100}, // R5 R6 slot 2
    {4'b1001, 4'b0100, 4'b1000}, // R5 slot 3
    {4'b0001, 4'b1000, 4'b0001}, // R5 wrap to slot 0
    {4'b0000, 4'b0001, 4'b0000}, // R7 nobody waiting
    {4'b0000, 4'b0000, 4'b0000}, // R7 stays idle
    {4'b0110, 4'b0000, 4'b0010}, // R4 R5 pointer at 1
    {4'b0010, 4'b0010, 4'b0000}, // R7 releasing owner excluded
    {4'b0010, 4'b0000, 4'b0010}, // R4 regrant through later decision
    {4'b0110, 4'b0000, 4'b0010}, // R3 hold while slot 2 waits
    {4'b1010, 4'b0010, 4'b1000}, // R8 slot 2 withdrew, slot 3 wins
    {4'b1111, 4'b1000, 4'b0001}, // R5 wrap after slot 3
    {4'b1111, 4'b0001, 4'b0010}  // R6 R2 back-to-back
  };

  task automatic check(input logic [3:0] exp, input string tag);
    checks++;
    if (gnt !== exp) begin
      fails++;
      $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
    end
    if (!$onehot0(gnt)) begin
      fails++;
      $display("FAIL R2: gnt=%b expected at most one bit set", gnt);
    end
  endtask

  task automatic step(input logic [3:0] r, input logic [3:0] f,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    req = r;
    fin = f;
    @(posedge clk);
    #1;
    check(exp, tag);
  endtask

  initial begin
    #(PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check(4'b0000, "R1 reset");
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++)
      step(VEC[i][11:8], VEC[i][7:4], VEC[i][3:0], $sformatf("vec%0d", i));

    // R1: reset in the middle of a transaction clears grant at once
    @(negedge clk);
    req = 4'b1111;
    fin = 4'b0000;
    rst_n = 1'b0;
    #1;
    check(4'b0000, "R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b1111, 4'b0000, 4'b0001, "R1 pointer restart");
    // R9: finish from every non-owner at once
    step(4'b1111, 4'b1110, 4'b0001, "R9 foreign finish");
    // R3: owner keeps bus with no requests at all
    step(4'b0000, 4'b0000, 4'b0001, "R3 hold without request");
    step(4'b0000, 4'b0001, 4'b0000, "R7 release to idle");

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule